// File: doc/BRIEF.md
# Mode-Aware Register and Status Unit

This block holds the programmer-visible register set of a small processor core: a 16-bit accumulator, two 16-bit index registers, a stack pointer, a direct page register, a data bank register, the eight status flags and the emulation bit. Each cycle it carries out one operation picked by an operation select. The operations are register transfers, setting or clearing status bits through an 8-bit mask, replacing the status byte with a pulled value, exchanging carry with the emulation bit, swapping the accumulator bytes and loading a register from a write-data bus. Instruction decode and memory access sit outside the block. Decode drives the operation select, and the memory path supplies the mask, the pulled byte and the write data.

The accumulator width follows m and the index width follows x. Emulation mode holds m and x at 1 and the stack page at 0x01. All outputs come straight from registers, so an operation applied in one cycle shows up on the outputs after the next rising clock edge.

Top module: `mode_reg_unit`

## Requirements
- R1: After a synchronous reset the accumulator, both index registers, the direct page and the data bank read 0, the stack pointer reads 0x01FF, the emulation bit is 1 and the status byte is 0x30. Status bit positions are n=7, v=6, m=5, x=4, d=3, i=2, z=1, c=0.
- R2: The set-bits operation ORs the mask into the status byte. The clear-bits operation ANDs the status byte with the inverted mask.
- R3: While emulation is 1, m and x read 1 after any status write, including a clear-bits mask or a pulled byte that has those bits at 0.
- R4: In any cycle that leaves x at 1, the upper bytes of both index registers read 0.
- R5: The exchange operation swaps c and e. When it turns emulation on it sets m and x and forces the stack upper byte to 0x01.
- R6: Accumulator-to-index with x=1 copies the low byte and keeps the destination's upper byte. With x=0 it copies all 16 bits whatever m is.
- R7: Index-to-accumulator with m=1 copies the low byte and keeps the accumulator's upper byte. With m=0 it copies 16 bits.
- R8: Stack-to-X with x=1 copies the low byte and zeroes X's upper byte. With x=0 it copies 16 bits.
- R9: Transfers into the stack pointer leave every flag unchanged. They copy 16 bits in native mode, and in emulation mode they copy the low byte with the upper byte at 0x01.
- R10: Every other transfer sets n from the top bit of the destination at its width and sets z when that width is all zero. The stack-to-accumulator, direct-page-to-accumulator and accumulator-to-direct-page transfers always use 16 bits.
- R11: The byte swap exchanges the accumulator's two bytes. It sets n from the new bit 7 and z from the new low byte, even when m=0.
- R12: Register loads take write data at the width of the destination: the accumulator by m, the index registers by x, the data bank always 8 bits. Each load sets n and z from the loaded value at that width.
- R13: The pull-status operation replaces the whole status byte with the pulled byte, with R3 and R4 still applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation select (package enumeration) |
| mask_i | input | 8 | Mask for set-bits / clear-bits |
| pull_i | input | 8 | Status byte for pull-status |
| wdata_i | input | 16 | Write data for register loads |
| acc_o | output | 16 | Accumulator |
| idx_x_o | output | 16 | X index register |
| idx_y_o | output | 16 | Y index register |
| sp_o | output | 16 | Stack pointer |
| dpage_o | output | 16 | Direct page register |
| dbank_o | output | 8 | Data bank register |
| stat_o | output | 8 | Status byte |
| emu_o | output | 1 | Emulation bit |

## Verification
Each transfer runs under both settings of its width flag. The values are chosen so that the upper and lower bytes differ and the 8-bit and 16-bit results give different n and z: the 0x55 low byte under an 0xFF upper byte sets n only when 16 bits count. Status writes are tried in native and emulation mode with masks and pulled bytes that clear m and x, which shows whether emulation really pins them. Transfers into the stack pointer run right after a byte swap that left z set, so a stray flag update would show up.

// File: rtl/mru_pkg.sv
package mru_pkg;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_NOP, OP_SETP, OP_CLRP, OP_PULLP, OP_XCE, OP_XBA,
    OP_TAX, OP_TAY, OP_TXA, OP_TYA, OP_TXY, OP_TYX,
    OP_TSX, OP_TXS, OP_TCS, OP_TSC, OP_TCD, OP_TDC,
    OP_LDA, OP_LDX, OP_LDY, OP_LDB
  } mru_op_e;

  // status bit positions (decoded by the mask operations)
  localparam int PB_N = 7;
  localparam int PB_V = 6;
  localparam int PB_M = 5;
  localparam int PB_X = 4;
  localparam int PB_D = 3;
  localparam int PB_I = 2;
  localparam int PB_Z = 1;
  localparam int PB_C = 0;
endpackage

// File: rtl/mru_xfer.sv
module mru_xfer
  import mru_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [OPW-1:0] op_i,
  input  logic           m_i,
  input  logic           x_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  x_reg_i,
  input  logic [DW-1:0]  y_reg_i,
  input  logic [DW-1:0]  s_i,
  input  logic [DW-1:0]  d_i,
  input  logic [DW/2-1:0] db_i,
  output logic [DW-1:0]  a_o,
  output logic [DW-1:0]  x_o,
  output logic [DW-1:0]  y_o,
  output logic [DW-1:0]  s_o,
  output logic [DW-1:0]  d_o,
  output logic [DW/2-1:0] db_o,
  output logic           nz_we_o,
  output logic           n_o,
  output logic           z_o
);
  localparam int H = DW / 2;

  logic [DW-1:0] res;
  logic          wide;

  always_comb begin
    a_o = a_i; x_o = x_reg_i; y_o = y_reg_i;
    s_o = s_i; d_o = d_i; db_o = db_i;
    res = '0; wide = 1'b1; nz_we_o = 1'b0;
    unique case (op_i)
      OP_TAX: begin
        x_o = x_i ? {x_reg_i[DW-1:H], a_i[H-1:0]} : a_i;
        res = x_o; wide = !x_i; nz_we_o = 1'b1;
      end
      OP_TAY: begin
        y_o = x_i ? {y_reg_i[DW-1:H], a_i[H-1:0]} : a_i;
        res = y_o; wide = !x_i; nz_we_o = 1'b1;
      end
      OP_TXA: begin
        a_o = m_i ? {a_i[DW-1:H], x_reg_i[H-1:0]} : x_reg_i;
        res = a_o; wide = !m_i; nz_we_o = 1'b1;
      end
      OP_TYA: begin
        a_o = m_i ? {a_i[DW-1:H], y_reg_i[H-1:0]} : y_reg_i;
        res = a_o; wide = !m_i; nz_we_o = 1'b1;
      end
      OP_TXY: begin
        y_o = x_i ? {y_reg_i[DW-1:H], x_reg_i[H-1:0]} : x_reg_i;
        res = y_o; wide = !x_i; nz_we_o = 1'b1;
      end
      OP_TYX: begin
        x_o = x_i ? {x_reg_i[DW-1:H], y_reg_i[H-1:0]} : y_reg_i;
        res = x_o; wide = !x_i; nz_we_o = 1'b1;
      end
      OP_TSX: begin
        x_o = x_i ? {{H{1'b0}}, s_i[H-1:0]} : s_i;
        res = x_o; wide = !x_i; nz_we_o = 1'b1;
      end
      OP_TXS: s_o = x_reg_i;
      OP_TCS: s_o = a_i;
      OP_TSC: begin a_o = s_i; res = s_i; nz_we_o = 1'b1; end
      OP_TDC: begin a_o = d_i; res = d_i; nz_we_o = 1'b1; end
      OP_TCD: begin d_o = a_i; res = a_i; nz_we_o = 1'b1; end
      OP_XBA: begin
        a_o = {a_i[H-1:0], a_i[DW-1:H]};
        res = a_o; wide = 1'b0; nz_we_o = 1'b1;
      end
      OP_LDA: begin
        a_o = m_i ? {a_i[DW-1:H], wdata_i[H-1:0]} : wdata_i;
        res = a_o; wide = !m_i; nz_we_o = 1'b1;
      end
      OP_LDX: begin
        x_o = x_i ? {x_reg_i[DW-1:H], wdata_i[H-1:0]} : wdata_i;
        res = x_o; wide = !x_i; nz_we_o = 1'b1;
      end
      OP_LDY: begin
        y_o = x_i ? {y_reg_i[DW-1:H], wdata_i[H-1:0]} : wdata_i;
        res = y_o; wide = !x_i; nz_we_o = 1'b1;
      end
      OP_LDB: begin
        db_o = wdata_i[H-1:0];
        res = {{H{1'b0}}, wdata_i[H-1:0]}; wide = 1'b0; nz_we_o = 1'b1;
      end
      default: ;
    endcase
    n_o = wide ? res[DW-1] : res[H-1];
    z_o = wide ? (res == '0) : (res[H-1:0] == '0);
  end
endmodule

// File: rtl/mru_status.sv
module mru_status
  import mru_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  logic [7:0]     mask_i,
  input  logic [7:0]     pull_i,
  input  logic [7:0]     p_i,
  input  logic           e_i,
  input  logic           nz_we_i,
  input  logic           n_i,
  input  logic           z_i,
  output logic [7:0]     p_o,
  output logic           e_o
);
  always_comb begin
    p_o = p_i;
    e_o = e_i;
    if (nz_we_i) begin
      p_o[PB_N] = n_i;
      p_o[PB_Z] = z_i;
    end
    unique case (op_i)
      OP_SETP:  p_o = p_i | mask_i;
      OP_CLRP:  p_o = p_i & ~mask_i;
      OP_PULLP: p_o = pull_i;
      OP_XCE: begin
        e_o       = p_i[PB_C];
        p_o[PB_C] = e_i;
      end
      default: ;
    endcase
    // emulation pins both width flags
    if (e_o) begin
      p_o[PB_M] = 1'b1;
      p_o[PB_X] = 1'b1;
    end
  end
endmodule

// File: rtl/mode_reg_unit.sv
module mode_reg_unit
  import mru_pkg::*;
#(
  parameter int         DW         = 16,
  parameter logic [7:0] STACK_PAGE = 8'h01,
  parameter logic [7:0] STACK_INIT = 8'hFF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OPW-1:0]  op_i,
  input  logic [7:0]      mask_i,
  input  logic [7:0]      pull_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   acc_o,
  output logic [DW-1:0]   idx_x_o,
  output logic [DW-1:0]   idx_y_o,
  output logic [DW-1:0]   sp_o,
  output logic [DW-1:0]   dpage_o,
  output logic [DW/2-1:0] dbank_o,
  output logic [7:0]      stat_o,
  output logic            emu_o
);
  localparam int H = DW / 2;
  localparam logic [7:0] P_RESET = 8'h30;

  logic [DW-1:0] a_q, x_q, y_q, s_q, d_q;
  logic [H-1:0]  db_q;
  logic [7:0]    p_q;
  logic          e_q;

  logic [DW-1:0] a_n, x_n, y_n, s_n, d_n;
  logic [H-1:0]  db_n;
  logic [7:0]    p_n;
  logic          e_n, nz_we, n_v, z_v;

  mru_xfer #(.DW(DW)) i_xfer (
    .op_i(op_i), .m_i(p_q[PB_M]), .x_i(p_q[PB_X]), .wdata_i(wdata_i),
    .a_i(a_q), .x_reg_i(x_q), .y_reg_i(y_q), .s_i(s_q), .d_i(d_q), .db_i(db_q),
    .a_o(a_n), .x_o(x_n), .y_o(y_n), .s_o(s_n), .d_o(d_n), .db_o(db_n),
    .nz_we_o(nz_we), .n_o(n_v), .z_o(z_v)
  );

  mru_status i_status (
    .op_i(op_i), .mask_i(mask_i), .pull_i(pull_i), .p_i(p_q), .e_i(e_q),
    .nz_we_i(nz_we), .n_i(n_v), .z_i(z_v), .p_o(p_n), .e_o(e_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q  <= '0;
      x_q  <= '0;
      y_q  <= '0;
      s_q  <= {STACK_PAGE, STACK_INIT};
      d_q  <= '0;
      db_q <= '0;
      p_q  <= P_RESET;
      e_q  <= 1'b1;
    end else begin
      a_q  <= a_n;
      d_q  <= d_n;
      db_q <= db_n;
      p_q  <= p_n;
      e_q  <= e_n;
      x_q  <= p_n[PB_X] ? {{H{1'b0}}, x_n[H-1:0]} : x_n;
      y_q  <= p_n[PB_X] ? {{H{1'b0}}, y_n[H-1:0]} : y_n;
      s_q  <= e_n ? {STACK_PAGE, s_n[H-1:0]} : s_n;
    end
  end

  assign acc_o   = a_q;
  assign idx_x_o = x_q;
  assign idx_y_o = y_q;
  assign sp_o    = s_q;
  assign dpage_o = d_q;
  assign dbank_o = db_q;
  assign stat_o  = p_q;
  assign emu_o   = e_q;

  // R3: emulation keeps both width flags at 1
  a_r3_emu_pins_mx: assert property (@(posedge clk) disable iff (rst)
    e_q |-> (p_q[PB_M] && p_q[PB_X]));

  // R4: narrow index mode keeps upper bytes clear
  a_r4_idx_high_zero: assert property (@(posedge clk) disable iff (rst)
    p_q[PB_X] |-> (x_q[DW-1:H] == '0 && y_q[DW-1:H] == '0));

  // R9: emulation stack page
  a_r9_emu_stack_page: assert property (@(posedge clk) disable iff (rst)
    e_q |-> (s_q[DW-1:H] == STACK_PAGE));

  // R9: stack-pointer transfers leave the flags alone
  a_r9_stack_flags_kept: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_TXS || op_i == OP_TCS) |=> ($stable(p_q) && $stable(e_q)));

  // R2: every mask bit reads set after the set-bits operation
  a_r2_setp_bits: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SETP) |=> ((p_q & $past(mask_i)) == $past(mask_i)));

  // R11: byte swap
  a_r11_xba_swap: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_XBA) |=> (a_q == {$past(a_q[H-1:0]), $past(a_q[DW-1:H])}));

  // R5: carry and emulation exchange
  a_r5_xce_swap: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_XCE) |=> (e_q == $past(p_q[PB_C]) && p_q[PB_C] == $past(e_q)));
endmodule

// File: tb/test_mode_reg_unit.sv
module test_mode_reg_unit;
  import mru_pkg::*;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] a, x, y, s, d;
    logic [7:0]  db, p;
    logic        e;
  } st_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_i = OP_NOP;
  logic [7:0]  mask_i = '0, pull_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] acc_o, idx_x_o, idx_y_o, sp_o, dpage_o;
  logic [7:0]  dbank_o, stat_o;
  logic        emu_o;

  int checks = 0, errors = 0;
  bit done = 0;
  st_t   ex;
  st_t   exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mode_reg_unit i_mode_reg_unit (
    .clk(clk), .rst(rst), .op_i(op_i), .mask_i(mask_i), .pull_i(pull_i),
    .wdata_i(wdata_i), .acc_o(acc_o), .idx_x_o(idx_x_o), .idx_y_o(idx_y_o),
    .sp_o(sp_o), .dpage_o(dpage_o), .dbank_o(dbank_o), .stat_o(stat_o),
    .emu_o(emu_o)
  );

  // driver: apply one operation for one cycle and queue the expected state
  task automatic issue(input mru_op_e op, input logic [7:0] msk,
                       input logic [7:0] pl, input logic [15:0] wd,
                       input string tag);
    @(negedge clk);
    op_i = op; mask_i = msk; pull_i = pl; wdata_i = wd;
    exp_q.push_back(ex);
    tag_q.push_back(tag);
    @(negedge clk);
    op_i = OP_NOP;
  endtask

  // monitor: compare just after the edge that registers the result
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        st_t   e;
        st_t   act;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        act = '{acc_o, idx_x_o, idx_y_o, sp_o, dpage_o, dbank_o, stat_o, emu_o};
        checks++;
        if (act !== e) begin
          errors++;
          $display("FAIL %s: actual a=%h x=%h y=%h s=%h d=%h db=%h p=%h e=%b expected a=%h x=%h y=%h s=%h d=%h db=%h p=%h e=%b",
                   t, act.a, act.x, act.y, act.s, act.d, act.db, act.p, act.e,
                   e.a, e.x, e.y, e.s, e.d, e.db, e.p, e.e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ex = '{16'h0000, 16'h0000, 16'h0000, 16'h01FF, 16'h0000, 8'h00, 8'h30, 1'b1};
    issue(OP_NOP, 8'h00, 8'h00, 16'h0000, "R1 reset state");

    ex.a = 16'h0080; ex.p = 8'hB0;
    issue(OP_LDA, 8'h00, 8'h00, 16'h1280, "R12 load A 8-bit");
    ex.p = 8'hB0;
    issue(OP_CLRP, 8'h30, 8'h00, 16'h0, "R3 clear m,x in emulation");
    ex.p = 8'hB1; ex.e = 1'b0;
    issue(OP_XCE, 8'h00, 8'h00, 16'h0, "R5 exchange to native");
    ex.p = 8'h81;
    issue(OP_CLRP, 8'h30, 8'h00, 16'h0, "R2 clear bits");
    ex.a = 16'h8000; ex.p = 8'h81;
    issue(OP_LDA, 8'h00, 8'h00, 16'h8000, "R12 load A 16-bit");
    ex.a = 16'h0080; ex.p = 8'h81;
    issue(OP_XBA, 8'h00, 8'h00, 16'h0, "R11 swap n from bit7");
    ex.a = 16'h8000; ex.p = 8'h03;
    issue(OP_XBA, 8'h00, 8'h00, 16'h0, "R11 swap z from low byte");
    ex.s = 16'h8000;
    issue(OP_TCS, 8'h00, 8'h00, 16'h0, "R9 TCS native flags kept");
    ex.x = 16'h1234; ex.p = 8'h01;
    issue(OP_LDX, 8'h00, 8'h00, 16'h1234, "R12 load X 16-bit");
    ex.y = 16'h1234;
    issue(OP_TXY, 8'h00, 8'h00, 16'h0, "R10 X to Y");
    ex.s = 16'h1234;
    issue(OP_TXS, 8'h00, 8'h00, 16'h0, "R9 TXS native 16-bit");
    ex.a = 16'h1234;
    issue(OP_TSC, 8'h00, 8'h00, 16'h0, "R10 S to A");
    ex.d = 16'h1234;
    issue(OP_TCD, 8'h00, 8'h00, 16'h0, "R10 A to D");
    ex.a = 16'hFF00; ex.p = 8'h81;
    issue(OP_LDA, 8'h00, 8'h00, 16'hFF00, "R12 load A");
    ex.x = 16'hFF00;
    issue(OP_TAX, 8'h00, 8'h00, 16'h0, "R6 A to X 16-bit");
    ex.p = 8'hA1;
    issue(OP_SETP, 8'h20, 8'h00, 16'h0, "R2 set m");
    ex.a = 16'hFF55; ex.p = 8'h21;
    issue(OP_LDA, 8'h00, 8'h00, 16'h0055, "R12 load A keeps high");
    ex.x = 16'hFF55; ex.p = 8'hA1;
    issue(OP_TAX, 8'h00, 8'h00, 16'h0, "R6 A to X 16-bit with m=1");
    ex.a = 16'hFF34; ex.p = 8'h21;
    issue(OP_TYA, 8'h00, 8'h00, 16'h0, "R7 Y to A 8-bit");
    ex.p = 8'h31; ex.x = 16'h0055; ex.y = 16'h0034;
    issue(OP_SETP, 8'h10, 8'h00, 16'h0, "R4 set x clears index high");
    ex.a = 16'hFF00; ex.p = 8'h33;
    issue(OP_LDA, 8'h00, 8'h00, 16'h0000, "R12 load A zero");
    ex.x = 16'h0000; ex.p = 8'h33;
    issue(OP_TAX, 8'h00, 8'h00, 16'h0, "R6 A to X 8-bit");
    ex.x = 16'h0034; ex.p = 8'h31;
    issue(OP_TSX, 8'h00, 8'h00, 16'h0, "R8 S to X 8-bit");
    ex.p = 8'h01;
    issue(OP_CLRP, 8'h30, 8'h00, 16'h0, "R2 clear m,x native");
    ex.x = 16'h1234;
    issue(OP_TSX, 8'h00, 8'h00, 16'h0, "R8 S to X 16-bit");
    ex.a = 16'h1234;
    issue(OP_TXA, 8'h00, 8'h00, 16'h0, "R7 X to A 16-bit");
    ex.p = 8'hC2;
    issue(OP_PULLP, 8'h00, 8'hC2, 16'h0, "R13 pull status");
    ex.p = 8'h10; ex.x = 16'h0034; ex.y = 16'h0034;
    issue(OP_PULLP, 8'h00, 8'h10, 16'h0, "R13 R4 pull sets x");
    ex.p = 8'hD3;
    issue(OP_SETP, 8'hC3, 8'h00, 16'h0, "R2 set several bits");
    ex.p = 8'hF2; ex.e = 1'b1; ex.s = 16'h0134;
    issue(OP_XCE, 8'h00, 8'h00, 16'h0, "R5 enter emulation");
    ex.x = 16'h00AB; ex.p = 8'hF0;
    issue(OP_LDX, 8'h00, 8'h00, 16'h00AB, "R12 load X 8-bit");
    ex.s = 16'h01AB;
    issue(OP_TXS, 8'h00, 8'h00, 16'h0, "R9 TXS emulation");
    ex.s = 16'h0134;
    issue(OP_TCS, 8'h00, 8'h00, 16'h0, "R9 TCS emulation");
    ex.p = 8'h30;
    issue(OP_PULLP, 8'h00, 8'h00, 16'h0, "R3 pull in emulation");
    ex.db = 8'h80; ex.p = 8'hB0;
    issue(OP_LDB, 8'h00, 8'h00, 16'h5580, "R12 load data bank");
    ex.a = 16'h1234; ex.p = 8'h30;
    issue(OP_TDC, 8'h00, 8'h00, 16'h0, "R10 D to A 16-bit");
    ex.p = 8'h31; ex.e = 1'b0;
    issue(OP_XCE, 8'h00, 8'h00, 16'h0, "R5 leave emulation");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule